// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external 16-bit asynchronous static RAM. The host sees a valid/ready handshake carrying one read or one write per request, with a 19-bit word address, write data, and a per-byte enable. Reads return their data with a one-cycle valid pulse. The controller produces every memory strobe: the address, a chip-enable pair of opposite polarity, an active-low write strobe, an active-low output enable, and two active-low byte-lane selects. It also produces the tri-state data bus as separate out, in and drive-enable signals.

Every access runs through a fixed sequence of phases: address setup, then the access or write pulse, then recovery. The length of each phase, in clocks, comes from parameters for the clock period and for each memory timing limit. Each length is the limit divided by the period, rounded up, with a floor of one clock. For writes, the output enable stays inactive for the whole cycle. The controller drives data only in a window that lags the write strobe by one clock. After every read, a turnaround phase gives the memory time to release the bus before anything else may happen.

Top module: `asramCtrl`

## Requirements
- R1: While reset is asserted and right after it is released, reqReady is 1 and rdValid is 0. All strobes are inactive: ramCeN=1, ramCe2=0, ramWeN=1, ramOeN=1, ramLbN=1 and ramUbN=1. ramDqOe is 0.
- R2: The memory is selected only during the read-access and write-pulse phases. Whenever it is selected, ramCeN is 0 and ramCe2 is 1 together. At every other time, ramCeN is 1 and ramCe2 is 0.
- R3: reqByteEn bit 0 enables lane ramDq[7:0] through ramLbN, and bit 1 enables lane ramDq[15:8] through ramUbN. An enabled lane's select is low exactly while the memory is selected. A disabled lane's select stays high for the whole access. When a read has a disabled lane, that lane of rdData returns 0.
- R4: ramAddr takes the request address when the request is accepted. It stays stable for as long as any strobe is active.
- R5: For a read, ramOeN is low for ACC clocks, with the memory selected. ACC is ceil(max(tAA,tOE)/period); it is 14 at the 4 ns default. rdValid pulses for one cycle, 1+ACC clocks after the accepting edge. The data it presents is ramDqIn, sampled on the last clock of the access.
- R6: For a write, ramWeN is low for exactly WP contiguous clocks. WP is the largest of ceil(tWP), ceil(tAW) and ceil(tDW)+1, each in clocks; it is 13 at the default. ramOeN stays high throughout a write cycle.
- R7: ramDqOe rises one clock after ramWeN falls and falls one clock after ramWeN rises. While ramDqOe is high, ramDqOut carries the request's write data.
- R8: After a read access, all strobes stay inactive for TURN clocks before reqReady returns. TURN is ceil(tHZ/period); it is 5 at the default. ramDqOe is never high while ramOeN is low.
- R9: reqReady is high only in the idle phase. It drops on the clock that accepts a request and returns when the recovery phase ends. A reqValid presented while reqReady is low is ignored: it causes no strobe and no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Word address |
| reqWdata | input | 16 | Write data |
| reqByteEn | input | 2 | Byte-lane enables (bit 0 low byte) |
| reqReady | output | 1 | Controller idle, request accepted when valid |
| rdData | output | 16 | Read data |
| rdValid | output | 1 | One-cycle read-data strobe |
| ramAddr | output | 19 | Memory address |
| ramCeN | output | 1 | Active-low chip enable |
| ramCe2 | output | 1 | Active-high chip enable |
| ramWeN | output | 1 | Active-low write strobe |
| ramOeN | output | 1 | Active-low output enable |
| ramLbN | output | 1 | Active-low low-byte select |
| ramUbN | output | 1 | Active-low high-byte select |
| ramDqOut | output | 16 | Data to the bus |
| ramDqIn | input | 16 | Data from the bus |
| ramDqOe | output | 1 | Drive enable for ramDqOut |

## Verification
The bench's memory model returns a filler pattern until the access has lasted ACC-1 clocks. A controller that captured read data early would therefore hand back the filler instead of the stored word. Single-lane writes followed by full-word reads expose a lane decode that strobes the wrong byte or both bytes, because the neighbour byte would be corrupted. The bench injects a request while the controller is busy and later reads its target address. A controller that accepted work outside idle would have overwritten that address or pulsed the write strobe twice. The bench also counts every cycle in which the controller drives the bus while the memory is driving it. This catches a missing or short turnaround between a read and a following write.

// File: rtl/asramPkg.sv
package asramPkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_RD_ACC, ST_RD_TURN, ST_WR_PULSE, ST_WR_REC
  } phaseT;

  typedef struct packed {
    logic load;     // take the request into the datapath
    logic sel;      // chip selected
    logic weAct;    // write strobe active
    logic oeAct;    // output enable active
    logic capture;  // sample read data this clock
  } strobeT;

  function automatic int cycFor(int tNs, int perNs);
    int c;
    c = (tNs + perNs - 1) / perNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asramSeq.sv
module asramSeq
  import asramPkg::*;
#(
  parameter int N_SETUP = 1,
  parameter int N_ACC   = 14,
  parameter int N_TURN  = 5,
  parameter int N_WP    = 13,
  parameter int N_WREC  = 1
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  output logic   reqReady,
  output strobeT strb
);

  localparam int MAXN = maxOf(maxOf(maxOf(N_SETUP, N_ACC), maxOf(N_TURN, N_WP)), N_WREC);
  localparam int CNT_W = $clog2(MAXN + 1);

  phaseT phase, nextPhase;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic wrQ, nextWr;

  always_comb begin
    nextPhase = phase;
    nextCnt   = cnt;
    nextWr    = wrQ;
    if (phase != ST_IDLE && cnt != '0) begin
      nextCnt = cnt - 1'b1;
    end else begin
      case (phase)
        ST_IDLE: if (reqValid) begin
          nextPhase = ST_SETUP;
          nextCnt   = CNT_W'(N_SETUP - 1);
          nextWr    = reqWrite;
        end
        ST_SETUP: begin
          if (wrQ) begin
            nextPhase = ST_WR_PULSE;
            nextCnt   = CNT_W'(N_WP - 1);
          end else begin
            nextPhase = ST_RD_ACC;
            nextCnt   = CNT_W'(N_ACC - 1);
          end
        end
        ST_RD_ACC: begin
          nextPhase = ST_RD_TURN;
          nextCnt   = CNT_W'(N_TURN - 1);
        end
        ST_WR_PULSE: begin
          nextPhase = ST_WR_REC;
          nextCnt   = CNT_W'(N_WREC - 1);
        end
        default: nextPhase = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= ST_IDLE;
      cnt   <= '0;
      wrQ   <= 1'b0;
    end else begin
      phase <= nextPhase;
      cnt   <= nextCnt;
      wrQ   <= nextWr;
    end
  end

  always_comb begin
    strb.load    = (phase == ST_IDLE) && reqValid;
    strb.sel     = (phase == ST_RD_ACC) || (phase == ST_WR_PULSE);
    strb.weAct   = (phase == ST_WR_PULSE);
    strb.oeAct   = (phase == ST_RD_ACC);
    strb.capture = (phase == ST_RD_ACC) && (cnt == '0);
  end

  assign reqReady = (phase == ST_IDLE);

  // R9
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

// File: rtl/asramPath.sv
module asramPath
  import asramPkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int WE_CYC = 13
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobeT                 strb,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  input  logic [DATA_W/8-1:0]    reqByteEn,
  output logic [DATA_W-1:0]      rdData,
  output logic                   rdValid,
  output logic [ADDR_W-1:0]      ramAddr,
  output logic                   ramCeN,
  output logic                   ramCe2,
  output logic                   ramWeN,
  output logic                   ramOeN,
  output logic [DATA_W/8-1:0]    laneSelN,
  output logic [DATA_W-1:0]      ramDqOut,
  input  logic [DATA_W-1:0]      ramDqIn,
  output logic                   ramDqOe
);

  localparam int LANES = DATA_W / 8;
  localparam int RUN_W = $clog2(WE_CYC + 2);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  enQ;
  logic              dqOeQ;
  logic [DATA_W-1:0] laneRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      enQ     <= '0;
      dqOeQ   <= 1'b0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strb.load) begin
        addrQ <= reqAddr;
        dataQ <= reqWdata;
        enQ   <= reqByteEn;
      end
      dqOeQ   <= strb.weAct;
      rdValid <= strb.capture;
      if (strb.capture) rdData <= laneRd;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneSelN[g]      = ~(strb.sel & enQ[g]);
    assign laneRd[g*8 +: 8] = enQ[g] ? ramDqIn[g*8 +: 8] : 8'h00;
  end

  assign ramAddr  = addrQ;
  assign ramCeN   = ~strb.sel;
  assign ramCe2   = strb.sel;
  assign ramWeN   = ~strb.weAct;
  assign ramOeN   = ~strb.oeAct;
  assign ramDqOut = dataQ;
  assign ramDqOe  = dqOeQ;

  // checker support: length of the current write-strobe run
  logic [RUN_W-1:0] weRun;
  always_ff @(posedge clk) begin
    if (!rstN)            weRun <= '0;
    else if (!ramWeN)     weRun <= weRun + 1'b1;
    else                  weRun <= '0;
  end

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sel && $past(strb.sel)) |-> $stable(ramAddr));

  // R7
  dq_late_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ramWeN) |=> ramDqOe);

  // R7
  dq_late_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramWeN) |-> (ramDqOe ##1 !ramDqOe));

  // R8
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ramDqOe && !ramOeN));

  // R5
  rdvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R6
  we_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ramWeN && weRun != '0) |-> (weRun == RUN_W'(WE_CYC)));

endmodule

// File: rtl/asramCtrl.sv
module asramCtrl
  import asramPkg::*;
#(
  parameter int CLK_NS = 4,
  parameter int T_AA   = 55,
  parameter int T_OE   = 30,
  parameter int T_HZ   = 20,
  parameter int T_AS   = 0,
  parameter int T_WC   = 55,
  parameter int T_WP   = 45,
  parameter int T_AW   = 50,
  parameter int T_DW   = 25,
  parameter int T_WR   = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [18:0] reqAddr,
  input  logic [15:0] reqWdata,
  input  logic [1:0]  reqByteEn,
  output logic        reqReady,
  output logic [15:0] rdData,
  output logic        rdValid,
  output logic [18:0] ramAddr,
  output logic        ramCeN,
  output logic        ramCe2,
  output logic        ramWeN,
  output logic        ramOeN,
  output logic        ramLbN,
  output logic        ramUbN,
  output logic [15:0] ramDqOut,
  input  logic [15:0] ramDqIn,
  output logic        ramDqOe
);

  localparam int N_SETUP = cycFor(T_AS, CLK_NS);
  localparam int N_ACC   = maxOf(cycFor(T_AA, CLK_NS), cycFor(T_OE, CLK_NS));
  localparam int N_TURN  = cycFor(T_HZ, CLK_NS);
  localparam int N_WP    = maxOf(maxOf(cycFor(T_WP, CLK_NS), cycFor(T_AW, CLK_NS)),
                                 cycFor(T_DW, CLK_NS) + 1);
  localparam int N_WREC  = maxOf(cycFor(T_WR, CLK_NS), cycFor(T_WC, CLK_NS) - N_WP);

  strobeT     strb;
  logic [1:0] laneSelN;

  asramSeq #(
    .N_SETUP(N_SETUP), .N_ACC(N_ACC), .N_TURN(N_TURN),
    .N_WP(N_WP), .N_WREC(N_WREC)
  ) i_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strb(strb)
  );

  asramPath #(.ADDR_W(19), .DATA_W(16), .WE_CYC(N_WP)) i_path (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqByteEn(reqByteEn),
    .rdData(rdData), .rdValid(rdValid),
    .ramAddr(ramAddr), .ramCeN(ramCeN), .ramCe2(ramCe2),
    .ramWeN(ramWeN), .ramOeN(ramOeN), .laneSelN(laneSelN),
    .ramDqOut(ramDqOut), .ramDqIn(ramDqIn), .ramDqOe(ramDqOe)
  );

  assign ramLbN = laneSelN[0];
  assign ramUbN = laneSelN[1];

endmodule

// File: tb/test_asramCtrl.sv
module test_asramCtrl;

  localparam int PER = 4;
  localparam int EXP_ACC  = ((55 + PER - 1) / PER > (30 + PER - 1) / PER) ?
                            (55 + PER - 1) / PER : (30 + PER - 1) / PER;   // 14
  localparam int EXP_WP   = (50 + PER - 1) / PER;                          // 13
  localparam int EXP_TURN = (20 + PER - 1) / PER;                          // 5

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqByteEn = '0;
  logic reqReady, rdValid;
  logic [15:0] rdData;
  logic [18:0] ramAddr;
  logic ramCeN, ramCe2, ramWeN, ramOeN, ramLbN, ramUbN, ramDqOe;
  logic [15:0] ramDqOut;
  wire  [15:0] ramDqIn;

  int total = 0, bad = 0;
  logic done = 1'b0;

  always #(PER / 2) clk = ~clk;

  asramCtrl i_asramCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqByteEn(reqByteEn),
    .reqReady(reqReady), .rdData(rdData), .rdValid(rdValid),
    .ramAddr(ramAddr), .ramCeN(ramCeN), .ramCe2(ramCe2), .ramWeN(ramWeN),
    .ramOeN(ramOeN), .ramLbN(ramLbN), .ramUbN(ramUbN),
    .ramDqOut(ramDqOut), .ramDqIn(ramDqIn), .ramDqOe(ramDqOe)
  );

  // memory model
  logic [15:0] mem [0:255];
  int rdCnt = 0;
  wire sel = !ramCeN && ramCe2;
  wire memDrive = sel && !ramOeN && (!ramLbN || !ramUbN);
  wire dataOk = rdCnt >= EXP_ACC - 1;

  assign ramDqIn[7:0]  = (sel && !ramOeN && !ramLbN) ?
                         (dataOk ? mem[ramAddr[7:0]][7:0] : 8'hAD) : 8'hzz;
  assign ramDqIn[15:8] = (sel && !ramOeN && !ramUbN) ?
                         (dataOk ? mem[ramAddr[7:0]][15:8] : 8'hDE) : 8'hzz;

  initial for (int i = 0; i < 256; i++) mem[i] = {i[7:0], ~i[7:0]};

  always @(posedge clk) begin
    rdCnt <= (sel && !ramOeN) ? rdCnt + 1 : 0;
    if (sel && !ramWeN && ramDqOe) begin
      if (!ramLbN) mem[ramAddr[7:0]][7:0]  <= ramDqOut[7:0];
      if (!ramUbN) mem[ramAddr[7:0]][15:8] <= ramDqOut[15:8];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one access; returns observed timing
  int firstWe, lastWe, weCnt, firstDq, lastDq, dqCnt, firstOe, lastOe, oeCnt;
  int validIdx, readyIdx, laneBad, addrBad, ceBad, conflict, oeInWrite;
  logic [15:0] gotData;

  task automatic runOp(input logic wr, input logic [18:0] a, input logic [15:0] d,
                       input logic [1:0] be, input logic inject);
    firstWe = 0; lastWe = 0; weCnt = 0; firstDq = 0; lastDq = 0; dqCnt = 0;
    firstOe = 0; lastOe = 0; oeCnt = 0; validIdx = 0; readyIdx = 0;
    laneBad = 0; addrBad = 0; ceBad = 0; conflict = 0; oeInWrite = 0; gotData = '0;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqByteEn = be;
    for (int idx = 1; idx < 200; idx++) begin
      @(negedge clk);
      if (idx == 1) begin reqValid = 1'b0; reqAddr = '0; reqWdata = '0; end
      if (inject && idx == 5) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 19'h0_00_C3;
        reqWdata = 16'h5A5A; reqByteEn = 2'b11;
      end
      if (inject && idx == 9) reqValid = 1'b0;
      if (ramCeN !== !ramCe2) ceBad++;
      if (sel) begin
        if (ramLbN !== !be[0] || ramUbN !== !be[1]) laneBad++;
        if (ramAddr !== a) addrBad++;
      end else if (!ramLbN || !ramUbN) laneBad++;
      if (!ramWeN) begin if (firstWe == 0) firstWe = idx; lastWe = idx; weCnt++; end
      if (ramDqOe) begin if (firstDq == 0) firstDq = idx; lastDq = idx; dqCnt++; end
      if (!ramOeN) begin if (firstOe == 0) firstOe = idx; lastOe = idx; oeCnt++; end
      if (wr && !ramOeN) oeInWrite++;
      if (ramDqOe && memDrive) conflict++;
      if (ramDqOe && ramDqOut !== d) addrBad++;
      if (rdValid) begin validIdx = idx; gotData = rdData; end
      if (reqReady && idx >= 2) begin readyIdx = idx; break; end
    end
    if (!wr) begin
      @(negedge clk);
      if (rdValid && validIdx == 0) begin validIdx = readyIdx + 1; gotData = rdData; end
    end
  endtask

  task automatic doWrite(input logic [18:0] a, input logic [15:0] d,
                         input logic [1:0] be, input logic inject);
    runOp(1'b1, a, d, be, inject);
    chk("R6 we first", firstWe, 2);
    chk("R6 we width", weCnt, EXP_WP);
    chk("R6 we contiguous", lastWe - firstWe + 1, EXP_WP);
    chk("R6 oe high in write", oeInWrite, 0);
    chk("R7 dq on lag", firstDq, firstWe + 1);
    chk("R7 dq off lag", lastDq, lastWe + 1);
    chk("R2 ce pair", ceBad, 0);
    chk("R3 lanes", laneBad, 0);
    chk("R4 addr/data", addrBad, 0);
    chk("R9 ready back", readyIdx, EXP_WP + 3);
  endtask

  task automatic doRead(input logic [18:0] a, input logic [1:0] be, input logic [15:0] exp);
    runOp(1'b0, a, 16'h0, be, 1'b0);
    chk("R5 oe width", oeCnt, EXP_ACC);
    chk("R5 oe start", firstOe, 2);
    chk("R5 valid latency", validIdx, EXP_ACC + 2);
    chk("R5 data", gotData, exp);
    chk("R8 turnaround", readyIdx - lastOe - 1, EXP_TURN);
    chk("R8 no contention", conflict, 0);
    chk("R6 no we in read", weCnt, 0);
    chk("R2 ce pair", ceBad, 0);
    chk("R3 lanes", laneBad, 0);
    chk("R4 addr", addrBad, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 ready", reqReady, 1);
    chk("R1 strobes", {ramCeN, ramCe2, ramWeN, ramOeN, ramLbN, ramUbN}, 6'b101111);
    chk("R1 dq oe", ramDqOe, 0);
    chk("R1 rdvalid", rdValid, 0);
  endtask

  task automatic testFullWord();
    doWrite(19'h2_10_11, 16'hBEEF, 2'b11, 1'b0);
    doRead(19'h2_10_11, 2'b11, 16'hBEEF);
  endtask

  task automatic testByteLanes();
    doWrite(19'h2_10_11, 16'h1122, 2'b01, 1'b0);
    doRead(19'h2_10_11, 2'b11, 16'hBE22);          // R3 upper kept
    doWrite(19'h2_10_11, 16'h7733, 2'b10, 1'b0);
    doRead(19'h2_10_11, 2'b11, 16'h7722);          // R3 lower kept
    doRead(19'h2_10_11, 2'b01, 16'h0022);          // R3 disabled lane reads 0
    doRead(19'h2_10_11, 2'b10, 16'h7700);
  endtask

  task automatic testBusyIgnore();
    doWrite(19'h0_00_40, 16'hCAFE, 2'b11, 1'b1);
    chk("R9 single strobe run", weCnt, EXP_WP);
    doRead(19'h0_00_C3, 2'b11, 16'hC33C);           // R9 injected write absent
    doRead(19'h0_00_40, 2'b11, 16'hCAFE);
  endtask

  task automatic testBackToBack();
    doRead(19'h0_00_05, 2'b11, 16'h05FA);
    doWrite(19'h0_00_06, 16'h0102, 2'b11, 1'b0);   // R8 write right after read
    doRead(19'h0_00_06, 2'b11, 16'h0102);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    testFullWord();
    testByteLanes();
    testBusyIgnore();
    testBackToBack();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule